// File: doc/BRIEF.md
# System Exception Pending Control and Status Register

This block is a 32-bit memory-mapped word that software uses to see and steer the state of the system exceptions. It owns the pending flags of three system exceptions: the non-maskable interrupt, the deferred service call and the periodic timer tick. On a read it builds a status word from the current exception state. That word shows the three pending flags, a summary bit that is set when any external interrupt is pending, the number of the best pending vector, a return-to-base flag and the number of the exception now being serviced.

On a write, software can set or clear those three pending flags. The deferred call and the timer tick resolve a simultaneous set and clear in opposite ways. Hardware can also raise the NMI and tick flags, and the exception entry logic clears a flag when its exception is taken. The priority search happens elsewhere. Its result arrives as the pending vector number. Whenever a pending flag changes, the block raises a one-cycle strobe so that the resolver searches again.

Top module: `icsr_reg`

## Requirements
- R1: A read (`rd_en` high) returns the status word on `rd_data` one clock later. That word shows NMI pending at bit 31, deferred call pending at bit 28 and tick pending at bit 26, all taken from state before any write in the same cycle. `rd_data` is zero in every cycle that follows a cycle without a read.
- R2: Read bit 22 is 1 exactly when at least one bit of `ext_pend` (exceptions 16 up to NUM_EXC-1) is set.
- R3: Read bits 20:12 carry `pend_vec_num`, read bits 8:0 carry `cur_active`, and the other unlisted bits read 0.
- R4: Read bit 11 (return-to-base) is 0 when some bit of `active_vec` other than the bit numbered `cur_active` is set. Otherwise it is 1.
- R5: Writing 1 to bit 31 makes NMI pending. Zero bits have no effect. Every bit other than 31, 28, 27, 26 and 25 is ignored.
- R6: Bit 28 sets the deferred call pending and bit 27 clears it. The clear is applied after the set, so writing both leaves it not pending.
- R7: Bit 26 sets tick pending and bit 25 clears it. The clear is honoured only when bit 26 is 0 in the same write.
- R8: `reeval` is high for exactly the one cycle in which a changed pending flag first appears at the outputs, and low otherwise.
- R9: `nmi_req` and `tick_req` set their flags. `taken_clr` bit 2 clears NMI, bit 1 clears the deferred call and bit 0 clears the tick. A hardware request wins over a taken-clear or a software clear in the same cycle.
- R10: After reset all three pending flags, `reeval` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| ext_pend | input | NUM_EXC-16 | Pending bits of exceptions 16 and up |
| active_vec | input | NUM_EXC | Active bit per exception number |
| pend_vec_num | input | VEC_W | Best pending vector from the resolver |
| cur_active | input | VEC_W | Exception number currently serviced |
| nmi_req | input | 1 | Hardware NMI request pulse |
| tick_req | input | 1 | Timer tick request pulse |
| taken_clr | input | 3 | Clear on exception entry {NMI, deferred call, tick} |
| nmi_pending | output | 1 | NMI pending flag |
| pendsv_pending | output | 1 | Deferred call pending flag |
| tick_pending | output | 1 | Tick pending flag |
| reeval | output | 1 | One-cycle request to re-run the priority search |

## Verification
The assertions assume that `rd_en` and `wr_en` are sampled cleanly at the clock edge. They also assume that `cur_active` and `active_vec` describe a consistent state, so that return-to-base reflects real nesting. The bench drives every input at the falling edge and holds it for a full cycle. It changes the status inputs only between reads and applies hardware requests, taken-clears and writes in the same cycle only where a precedence rule is under test.

// File: rtl/icsr_pkg.sv
// Package: shared bit positions and exception numbers for the pending
// control and status register. Assumes a 32-bit register word.
package icsr_pkg;
    localparam int WORD_W = 32;

    // Write command bits
    localparam int W_NMI_SET  = 31;
    localparam int W_PSV_SET  = 28;
    localparam int W_PSV_CLR  = 27;
    localparam int W_TICK_SET = 26;
    localparam int W_TICK_CLR = 25;

    // Read status fields
    localparam int R_NMI      = 31;
    localparam int R_PSV      = 28;
    localparam int R_TICK     = 26;
    localparam int R_EXT_ANY  = 22;
    localparam int R_PVEC_LO  = 12;
    localparam int R_RTB      = 11;
    localparam int R_AVEC_LO  = 0;

    // Index of each system flag in the taken-clear vector
    localparam int F_NMI  = 2;
    localparam int F_PSV  = 1;
    localparam int F_TICK = 0;

    localparam int FIRST_EXT = 16;
endpackage

// File: rtl/icsr_flag.sv
// Module: one pending flag with software set/clear, hardware set and
// clear-on-entry. CLEAR_LAST chooses whether the software clear is applied
// after the software set (clear wins) or only when no set is present.
// A hardware set always wins. Assumes all inputs are single-cycle strobes.
module icsr_flag #(
    parameter bit CLEAR_LAST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    input  logic ack,
    output logic flag,
    output logic changing
);
    logic nxt;

    // Next-state with the precedence chosen by CLEAR_LAST
    generate
        if (CLEAR_LAST) begin : g_clear_last
            always_comb nxt = (((flag & ~ack) | sw_set) & ~sw_clr) | hw_set;
        end else begin : g_set_wins
            always_comb nxt = ((flag & ~ack) & ~(sw_clr & ~sw_set)) | sw_set | hw_set;
        end
    endgenerate

    // Flag that this cycle's update alters the stored state
    always_comb changing = (nxt != flag);

    // Pending flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= nxt;
    end
endmodule

// File: rtl/icsr_status.sv
// Module: summary terms for the status word: any external interrupt pending,
// and return-to-base (no active exception other than the current one).
// Assumes active_vec bit i stands for exception number i.
module icsr_status #(
    parameter int NUM_EXC = 256,
    parameter int VEC_W   = 9,
    localparam int NUM_EXT = NUM_EXC - 16
) (
    input  logic [NUM_EXT-1:0] ext_pend,
    input  logic [NUM_EXC-1:0] active_vec,
    input  logic [VEC_W-1:0]   cur_active,
    output logic               ext_any,
    output logic               ret_base
);
    logic [NUM_EXC-1:0] other_active;

    // Mark each active exception that is not the current one
    generate
        for (genvar i = 0; i < NUM_EXC; i++) begin : g_other
            assign other_active[i] = active_vec[i] & (cur_active != VEC_W'(i));
        end
    endgenerate

    // Reduce to the two summary bits
    always_comb begin
        ext_any  = |ext_pend;
        ret_base = ~|other_active;
    end
endmodule

// File: rtl/icsr_reg.sv
// Module: top of the pending control and status register. Holds the three
// system pending flags, decodes writes into set/clear strobes, builds the
// status word live and registers it on a read. Raises reeval for one cycle
// when a flag changes. Assumes the priority search is external.
module icsr_reg
    import icsr_pkg::*;
#(
    parameter int NUM_EXC = 256,
    parameter int VEC_W   = 9,
    localparam int NUM_EXT = NUM_EXC - 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [NUM_EXT-1:0] ext_pend,
    input  logic [NUM_EXC-1:0] active_vec,
    input  logic [VEC_W-1:0]   pend_vec_num,
    input  logic [VEC_W-1:0]   cur_active,
    input  logic               nmi_req,
    input  logic               tick_req,
    input  logic [2:0]         taken_clr,
    output logic               nmi_pending,
    output logic               pendsv_pending,
    output logic               tick_pending,
    output logic               reeval
);
    logic [WORD_W-1:0] wq;
    logic [2:0]        chg;
    logic              ext_any;
    logic              ret_base;
    logic [WORD_W-1:0] status_word;

    // Gate write data with the write strobe
    always_comb wq = wr_en ? wr_data : '0;

    icsr_flag #(.CLEAR_LAST(1'b0)) u_nmi (
        .clk(clk), .rst_n(rst_n),
        .sw_set(wq[W_NMI_SET]), .sw_clr(1'b0), .hw_set(nmi_req),
        .ack(taken_clr[F_NMI]), .flag(nmi_pending), .changing(chg[F_NMI])
    );

    icsr_flag #(.CLEAR_LAST(1'b1)) u_psv (
        .clk(clk), .rst_n(rst_n),
        .sw_set(wq[W_PSV_SET]), .sw_clr(wq[W_PSV_CLR]), .hw_set(1'b0),
        .ack(taken_clr[F_PSV]), .flag(pendsv_pending), .changing(chg[F_PSV])
    );

    icsr_flag #(.CLEAR_LAST(1'b0)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .sw_set(wq[W_TICK_SET]), .sw_clr(wq[W_TICK_CLR]), .hw_set(tick_req),
        .ack(taken_clr[F_TICK]), .flag(tick_pending), .changing(chg[F_TICK])
    );

    icsr_status #(.NUM_EXC(NUM_EXC), .VEC_W(VEC_W)) u_status (
        .ext_pend(ext_pend), .active_vec(active_vec), .cur_active(cur_active),
        .ext_any(ext_any), .ret_base(ret_base)
    );

    // Assemble the status word from current state
    always_comb begin
        status_word = '0;
        status_word[R_NMI]     = nmi_pending;
        status_word[R_PSV]     = pendsv_pending;
        status_word[R_TICK]    = tick_pending;
        status_word[R_EXT_ANY] = ext_any;
        status_word[R_PVEC_LO +: VEC_W] = pend_vec_num;
        status_word[R_RTB]     = ret_base;
        status_word[R_AVEC_LO +: VEC_W] = cur_active;
    end

    // Register read data (one-clock access) and the re-evaluate strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            reeval  <= 1'b0;
        end else begin
            rd_data <= rd_en ? status_word : '0;
            reeval  <= |chg;
        end
    end
endmodule

// File: rtl/icsr_reg_chk.sv
// Module: assertion checker for icsr_reg, bound to every instance.
// Assumes the synchronous active-low reset is asserted at time zero.
module icsr_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        nmi_req,
    input logic        tick_req,
    input logic [2:0]  taken_clr,
    input logic        nmi_pending,
    input logic        pendsv_pending,
    input logic        tick_pending,
    input logic        reeval
);
    // R1: no read in the previous cycle gives zero read data
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == 32'h0));

    // R1: read shows NMI pending state from the read cycle
    p_read_nmi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[31] == $past(nmi_pending)));

    // R5: NMI set bit makes NMI pending
    p_nmi_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31]) |=> nmi_pending);

    // R6: set and clear together leave the deferred call not pending
    p_psv_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[28] && wr_data[27]) |=> !pendsv_pending);

    // R7: tick set bit wins over tick clear
    p_tick_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[26]) |=> tick_pending);

    // R8: strobe only when the flags differ from the previous cycle
    p_reeval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reeval |-> ({nmi_pending, pendsv_pending, tick_pending}
                    != $past({nmi_pending, pendsv_pending, tick_pending})));

    // R9: no stimulus leaves the flags unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !nmi_req && !tick_req && (taken_clr == 3'b000))
        |=> $stable({nmi_pending, pendsv_pending, tick_pending}));
endmodule

bind icsr_reg icsr_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .nmi_req(nmi_req), .tick_req(tick_req),
    .taken_clr(taken_clr), .nmi_pending(nmi_pending),
    .pendsv_pending(pendsv_pending), .tick_pending(tick_pending),
    .reeval(reeval)
);

// File: tb/icsr_reg_bench.sv
module icsr_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EXC = 256;
    localparam int VEC_W   = 9;
    localparam int NUM_EXT = NUM_EXC - 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_data = '0;
    logic               rd_en = 1'b0;
    logic [31:0]        rd_data;
    logic [NUM_EXT-1:0] ext_pend = '0;
    logic [NUM_EXC-1:0] active_vec = '0;
    logic [VEC_W-1:0]   pend_vec_num = '0;
    logic [VEC_W-1:0]   cur_active = '0;
    logic               nmi_req = 1'b0;
    logic               tick_req = 1'b0;
    logic [2:0]         taken_clr = '0;
    logic               nmi_pending, pendsv_pending, tick_pending, reeval;

    int checks = 0;
    int errors = 0;

    icsr_reg #(.NUM_EXC(NUM_EXC), .VEC_W(VEC_W)) u_icsr_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ext_pend(ext_pend),
        .active_vec(active_vec), .pend_vec_num(pend_vec_num),
        .cur_active(cur_active), .nmi_req(nmi_req), .tick_req(tick_req),
        .taken_clr(taken_clr), .nmi_pending(nmi_pending),
        .pendsv_pending(pendsv_pending), .tick_pending(tick_pending),
        .reeval(reeval)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Write data, then expected {nmi, pendsv, tick} after the write
    localparam logic [34:0] VEC_TBL [0:11] = '{
        {32'h1000_0000, 3'b010},   // R6 set
        {32'h0400_0000, 3'b011},   // R7 set
        {32'h0C00_0000, 3'b001},   // R6 clear, R7 set again
        {32'h0600_0000, 3'b001},   // R7 set wins over clear
        {32'h0200_0000, 3'b000},   // R7 clear alone
        {32'h1800_0000, 3'b000},   // R6 set+clear -> clear
        {32'h1000_0000, 3'b010},   // R6 set
        {32'h0000_0000, 3'b010},   // R5 zeros no effect
        {32'h61BF_FFFF, 3'b010},   // R5 other bits ignored
        {32'h8000_0000, 3'b110},   // R5 NMI set
        {32'h0400_0000, 3'b111},   // R7 set
        {32'h0A00_0000, 3'b100}    // R6/R7 clears
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, results visible at the next falling edge
    task automatic cyc(input logic we, input logic [31:0] d, input logic nr,
                       input logic tr, input logic [2:0] tc);
        @(negedge clk);
        wr_en = we; wr_data = d; nmi_req = nr; tick_req = tr; taken_clr = tc;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; nmi_req = 1'b0; tick_req = 1'b0; taken_clr = '0;
    endtask

    task automatic rd(output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    function automatic logic [2:0] flags();
        return {nmi_pending, pendsv_pending, tick_pending};
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 flags", {29'h0, flags()}, 32'h0);
        chk("R10 reeval", {31'h0, reeval}, 32'h0);
        chk("R10 rd_data", rd_data, 32'h0);

        // Table walk: R5 R6 R7 R8 R1
        prev = 3'b000;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, VEC_TBL[i][34:3], 1'b0, 1'b0, 3'b000);
            chk($sformatf("R5/R6/R7 entry %0d flags", i), {29'h0, flags()}, {29'h0, VEC_TBL[i][2:0]});
            chk($sformatf("R8 entry %0d reeval", i), {31'h0, reeval},
                {31'h0, (VEC_TBL[i][2:0] != prev)});
            rd(v);
            chk($sformatf("R1 entry %0d read bits", i), {29'h0, v[31], v[28], v[26]},
                {29'h0, VEC_TBL[i][2:0]});
            prev = VEC_TBL[i][2:0];
        end

        // R1: idle cycle after a read gives zero
        @(negedge clk);
        chk("R1 idle zero", rd_data, 32'h0);

        // R8: strobe drops one cycle after a change
        cyc(1'b1, 32'h1000_0000, 1'b0, 1'b0, 3'b000);
        chk("R8 strobe high", {31'h0, reeval}, 32'h1);
        @(negedge clk);
        chk("R8 strobe one cycle", {31'h0, reeval}, 32'h0);
        cyc(1'b1, 32'h0800_0000, 1'b0, 1'b0, 3'b000);

        // R2 R3 R4 full word, flags now {nmi=1, others 0}
        pend_vec_num = 9'h1A5; cur_active = 9'h0FF;
        rd(v);
        chk("R3 R4 word no ext", v, 32'h8000_0000 | (32'h1A5 << 12) | (32'h1 << 11) | 32'h0FF);
        ext_pend = '0; ext_pend[0] = 1'b1;
        rd(v);
        chk("R2 ext lowest", {31'h0, v[22]}, 32'h1);
        ext_pend = '0; ext_pend[NUM_EXT-1] = 1'b1;
        rd(v);
        chk("R2 ext highest", {31'h0, v[22]}, 32'h1);
        ext_pend = '0;
        cur_active = 9'd20; active_vec = '0; active_vec[20] = 1'b1;
        rd(v);
        chk("R4 only current active", {31'h0, v[11]}, 32'h1);
        active_vec[3] = 1'b1;
        rd(v);
        chk("R4 other active", {31'h0, v[11]}, 32'h0);
        chk("R3 active field", {23'h0, v[8:0]}, 32'd20);
        active_vec = '0;

        // R9 hardware set and taken-clear
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 3'b100);
        chk("R9 nmi taken clear", {29'h0, flags()}, 32'h0);
        chk("R8 strobe on taken clear", {31'h0, reeval}, 32'h1);
        cyc(1'b0, 32'h0, 1'b0, 1'b1, 3'b001);
        chk("R9 tick req beats taken", {29'h0, flags()}, 32'h1);
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 3'b001);
        chk("R9 tick taken clear", {29'h0, flags()}, 32'h0);
        cyc(1'b1, 32'h0200_0000, 1'b0, 1'b1, 3'b000);
        chk("R9 tick req beats sw clear", {29'h0, flags()}, 32'h1);
        cyc(1'b0, 32'h0, 1'b1, 1'b0, 3'b001);
        chk("R9 nmi req", {29'h0, flags()}, 32'h4);
        cyc(1'b1, 32'h1000_0000, 1'b0, 1'b0, 3'b000);
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 3'b010);
        chk("R9 psv taken clear", {29'h0, flags()}, 32'h4);

        // R1: read sees state before a same-cycle write
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h0400_0000;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R1 read before write", {29'h0, rd_data[31], rd_data[28], rd_data[26]}, 32'h4);
        chk("R7 write applied", {29'h0, flags()}, 32'h5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule